// File: doc/BRIEF.md
# Dispatch Group Slot Gate

This block sits beside an in-order issue stage and decides whether the next candidate instruction may join the dispatch group being formed. Each candidate is presented with a three-bit class code and five flags: first-only, single, cracked, writes-the-count-register and branches-through-the-count-register. The gate answers at once, with no clock delay, with one of three verdicts: accept, stall until a fresh group opens, or insert a no-op first. A group holds five slots. Only a branch may take the last slot. Some classes and flags are limited to the early slots of a group.

The issue stage pulses `issue_strb` when it sends the candidate, or `idle_strb` in a cycle where it sends nothing. The gate counts the occupied slots and remembers whether the count register has been written in the current group. A strobe that breaks the handshake raises `proto_err` and is ignored.

The state machine has two states. GS_EMPTY means no slot is used. GS_OPEN means one to four slots are used. The transitions are:
- GS_EMPTY to GS_OPEN on a legal issue or an idle strobe that leaves the occupancy below five.
- GS_OPEN to GS_EMPTY when a legal issue or an idle strobe brings the occupancy to five.
- GS_EMPTY to GS_EMPTY when a closing issue (branch or single) fills the whole group at once.
- Either state back to GS_EMPTY on reset.

Top module: `dgrp_slot_gate`

## Requirements
- R1: When four slots are used, a candidate of any class other than branch (class 6) or pseudo (class 7) gets verdict stall (2'b01). A branch is accepted (2'b00).
- R2: A candidate with the first-only or the single flag set gets stall unless the group is empty (`slots_used` == 0).
- R3: A cracked candidate gets stall when more than two slots are used. When accepted and issued, it adds two slots.
- R4: A condition-register candidate (class 5) gets stall when two or more slots are used.
- R5: A legal issue of a branch, or of a single-flagged candidate, closes the group. On the next cycle `slots_used` is 0 and `ctr_armed` is 0.
- R6: A lone idle strobe adds one slot. When the occupancy reaches five, the group ends and both the count and `ctr_armed` clear.
- R7: A legal issue with the count-register-write flag sets `ctr_armed`. While it is set, a candidate with the branch-through-count flag gets verdict no-op (2'b10). When the group ends the flag clears and such a candidate is accepted again.
- R8: A pseudo candidate (class 7) always gets accept, whatever its flags. Issuing it changes neither `slots_used` nor `ctr_armed`.
- R9: When a candidate meets both a stall condition and the no-op condition, the verdict is stall.
- R10: `proto_err` is high in any cycle with both strobes high, or with `issue_strb` high while the verdict is not accept. Such a cycle leaves the state unchanged.
- R11: A synchronous reset gives `slots_used` 0 and `ctr_armed` 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cand_class | input | 3 | Class code: 0 fixed-point, 1 load/store, 2 floating-point, 3 vector ALU, 4 vector permute, 5 condition-register, 6 branch, 7 pseudo |
| cand_first_only | input | 1 | Candidate must open a group |
| cand_single | input | 1 | Candidate must open a group and then closes it |
| cand_cracked | input | 1 | Candidate splits into two slots |
| cand_sets_ctr | input | 1 | Candidate writes the count register |
| cand_uses_ctr | input | 1 | Candidate branches through the count register |
| issue_strb | input | 1 | Candidate is issued this cycle |
| idle_strb | input | 1 | Nothing is issued this cycle |
| verdict | output | 2 | 00 accept, 01 stall, 10 insert no-op |
| slots_used | output | 3 | Slots occupied in the current group |
| ctr_armed | output | 1 | Count register written in this group |
| proto_err | output | 1 | Illegal strobe combination this cycle |

## Verification
The bench walks one sequence of candidates through every occupancy level from zero to four. At each level it presents each class that the slot rules treat differently, so a limit that is off by one slot shows up as a wrong verdict at the level where it matters. Groups are ended in three ways: a branch, a single-flagged instruction, and idle strobes that fill the group. A count or flag that is not cleared correctly then shows up at the next candidate. The count-register case is tried with the flag set and clear, and together with a stall condition, which separates the no-op answer from stall. Illegal strobe pairs and issues of non-accepted candidates are checked for leaving the visible state untouched.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

    typedef enum logic [2:0] {
        CL_FXU    = 3'd0,
        CL_LSU    = 3'd1,
        CL_FPU    = 3'd2,
        CL_VALU   = 3'd3,
        CL_VPERM  = 3'd4,
        CL_CREG   = 3'd5,
        CL_BRANCH = 3'd6,
        CL_PSEUDO = 3'd7
    } cls_e;

    typedef enum logic [1:0] {
        VD_ACCEPT = 2'b00,
        VD_STALL  = 2'b01,
        VD_NOOP   = 2'b10
    } verdict_e;

    typedef enum logic {
        GS_EMPTY = 1'b0,
        GS_OPEN  = 1'b1
    } grp_state_e;

endpackage

// File: rtl/dgrp_verdict.sv
module dgrp_verdict
    import dgrp_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CR_SLOTS    = 2,
    parameter int CRACK_LIMIT = 2,
    parameter int CNT_W       = 3
) (
    input  cls_e             cls,
    input  logic             first_only,
    input  logic             single,
    input  logic             cracked,
    input  logic             uses_ctr,
    input  logic [CNT_W-1:0] used,
    input  logic             armed,
    output verdict_e         verdict
);

    localparam int LAST_IDX = GROUP_SLOTS - 1;

    logic must_lead;
    logic crack_full;
    logic creg_late;
    logic tail_blocked;

    always_comb begin
        must_lead    = (first_only || single) && (used != '0);
        crack_full   = cracked && (int'(used) > CRACK_LIMIT);
        creg_late    = (cls == CL_CREG) && (int'(used) >= CR_SLOTS);
        tail_blocked = (cls != CL_BRANCH) && (int'(used) == LAST_IDX);

        if (cls == CL_PSEUDO) begin
            verdict = VD_ACCEPT;
        end else if (must_lead || crack_full || creg_late || tail_blocked) begin
            verdict = VD_STALL;
        end else if (armed && uses_ctr) begin
            verdict = VD_NOOP;
        end else begin
            verdict = VD_ACCEPT;
        end
    end

    // R8: the pseudo class is never held back
    always_comb begin
        if (cls == CL_PSEUDO) begin
            a_r8_pseudo_accept: assert (verdict == VD_ACCEPT);
        end
    end

endmodule

// File: rtl/dgrp_occupancy.sv
module dgrp_occupancy
    import dgrp_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CNT_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_ok,
    input  logic             idle_ok,
    input  logic             closes,
    input  logic             cracked,
    input  logic             sets_ctr,
    output logic [CNT_W-1:0] used,
    output logic             armed
);

    localparam int SUM_W = CNT_W + 1;

    grp_state_e       st_q, st_d;
    logic [CNT_W-1:0] used_q, used_d;
    logic             armed_q, armed_d;
    logic [SUM_W-1:0] grow;
    logic [SUM_W-1:0] sum;
    logic             fills;

    always_comb begin
        grow = '0;
        if (issue_ok) begin
            if (closes) begin
                grow = SUM_W'(GROUP_SLOTS) - SUM_W'(used_q);
            end else begin
                grow = SUM_W'(1) + SUM_W'(cracked);
            end
        end else if (idle_ok) begin
            grow = SUM_W'(1);
        end
        sum   = SUM_W'(used_q) + grow;
        fills = (int'(sum) >= GROUP_SLOTS);

        st_d    = st_q;
        used_d  = used_q;
        armed_d = armed_q;
        unique case (st_q)
            GS_EMPTY: begin
                if (grow != '0) begin
                    if (fills) begin
                        st_d    = GS_EMPTY;
                        used_d  = '0;
                        armed_d = 1'b0;
                    end else begin
                        st_d    = GS_OPEN;
                        used_d  = CNT_W'(sum);
                        armed_d = issue_ok && sets_ctr;
                    end
                end
            end
            GS_OPEN: begin
                if (grow != '0) begin
                    if (fills) begin
                        st_d    = GS_EMPTY;
                        used_d  = '0;
                        armed_d = 1'b0;
                    end else begin
                        used_d  = CNT_W'(sum);
                        armed_d = armed_q || (issue_ok && sets_ctr);
                    end
                end
            end
            default: begin
                st_d    = GS_EMPTY;
                used_d  = '0;
                armed_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= GS_EMPTY;
            used_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            used_q  <= used_d;
            armed_q <= armed_d;
        end
    end

    always_comb begin
        used  = used_q;
        armed = armed_q;
    end

    // R6: the slot count never rests at the group size
    a_r6_below_limit: assert property (@(posedge clk) disable iff (rst)
        int'(used_q) < GROUP_SLOTS);

    // R6: an idle strobe adds exactly one slot or ends the group
    a_r6_idle_step: assert property (@(posedge clk) disable iff (rst)
        (idle_ok && !issue_ok && int'(used_q) < GROUP_SLOTS - 1)
            |=> (used_q == $past(used_q) + CNT_W'(1)));

endmodule

// File: rtl/dgrp_slot_gate.sv
module dgrp_slot_gate
    import dgrp_pkg::*;
#(
    parameter int GROUP_SLOTS = 5,
    parameter int CR_SLOTS    = 2,
    parameter int CRACK_LIMIT = 2,
    localparam int CNT_W      = $clog2(GROUP_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cand_class,
    input  logic             cand_first_only,
    input  logic             cand_single,
    input  logic             cand_cracked,
    input  logic             cand_sets_ctr,
    input  logic             cand_uses_ctr,
    input  logic             issue_strb,
    input  logic             idle_strb,
    output logic [1:0]       verdict,
    output logic [CNT_W-1:0] slots_used,
    output logic             ctr_armed,
    output logic             proto_err
);

    cls_e             cls_w;
    verdict_e         vd_w;
    logic [CNT_W-1:0] used_w;
    logic             armed_w;
    logic             is_pseudo;
    logic             issue_ok;
    logic             idle_ok;
    logic             closes;

    assign cls_w     = cls_e'(cand_class);
    assign is_pseudo = (cls_w == CL_PSEUDO);

    dgrp_verdict #(
        .GROUP_SLOTS (GROUP_SLOTS),
        .CR_SLOTS    (CR_SLOTS),
        .CRACK_LIMIT (CRACK_LIMIT),
        .CNT_W       (CNT_W)
    ) u_verdict (
        .cls        (cls_w),
        .first_only (cand_first_only),
        .single     (cand_single),
        .cracked    (cand_cracked),
        .uses_ctr   (cand_uses_ctr),
        .used       (used_w),
        .armed      (armed_w),
        .verdict    (vd_w)
    );

    always_comb begin
        proto_err = (issue_strb && idle_strb) ||
                    (issue_strb && (vd_w != VD_ACCEPT));
        issue_ok  = issue_strb && !proto_err && !is_pseudo;
        idle_ok   = idle_strb && !proto_err;
        closes    = (cls_w == CL_BRANCH) || cand_single;
    end

    dgrp_occupancy #(
        .GROUP_SLOTS (GROUP_SLOTS),
        .CNT_W       (CNT_W)
    ) u_occ (
        .clk      (clk),
        .rst      (rst),
        .issue_ok (issue_ok),
        .idle_ok  (idle_ok),
        .closes   (closes),
        .cracked  (cand_cracked),
        .sets_ctr (cand_sets_ctr),
        .used     (used_w),
        .armed    (armed_w)
    );

    assign verdict    = vd_w;
    assign slots_used = used_w;
    assign ctr_armed  = armed_w;

    // R1: a non-branch candidate in the last slot is held
    a_r1_tail_branch_only: assert property (@(posedge clk) disable iff (rst)
        (int'(slots_used) == GROUP_SLOTS - 1 && cls_w != CL_BRANCH && !is_pseudo)
            |-> (verdict == VD_STALL));

    // R5: a legal closing issue empties the group
    a_r5_close_group: assert property (@(posedge clk) disable iff (rst)
        (issue_strb && !proto_err && !is_pseudo && closes)
            |=> (slots_used == '0 && !ctr_armed));

    // R7: the count-register flag never outlives its group
    a_r7_flag_in_group: assert property (@(posedge clk) disable iff (rst)
        (slots_used == '0) |-> !ctr_armed);

    // R8: issuing a pseudo candidate leaves the state alone
    a_r8_pseudo_quiet: assert property (@(posedge clk) disable iff (rst)
        (issue_strb && !idle_strb && is_pseudo)
            |=> ($stable(slots_used) && $stable(ctr_armed)));

    // R10: a rejected strobe changes nothing
    a_r10_err_hold: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> ($stable(slots_used) && $stable(ctr_armed)));

    // R11: reset always yields an empty group
    a_r11_reset_empty: assert property (@(posedge clk)
        rst |=> (slots_used == '0 && !ctr_armed));

endmodule

// File: tb/dgrp_slot_gate_bench.sv
module dgrp_slot_gate_bench;

    typedef struct packed {
        logic [2:0] cls;
        logic       fo;
        logic       sg;
        logic       ck;
        logic       sc;
        logic       uc;
        logic       iss;
        logic       idl;
        logic [1:0] ev;
        logic [2:0] eu;
        logic       ea;
        logic       ee;
    } vec_t;

    localparam int NV = 26;

    // fields: class, first, single, cracked, sets_ctr, uses_ctr, issue, idle,
    //         expected verdict, slots after edge, armed after edge, error
    localparam vec_t TBL [NV] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0}, // R1 FX at 0
        '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd2, 1'b0, 1'b0}, // R4 CR at 1
        '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd2, 1'b0, 1'b0}, // R4 CR at 2
        '{3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd4, 1'b0, 1'b0}, // R3 crack at 2
        '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd4, 1'b0, 1'b0}, // R1 FP at 4
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0}, // R1 branch at 4
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0}, // R2 first at 0
        '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd1, 1'b0, 1'b0}, // R2 single at 1
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd2, 1'b0, 1'b0}, // R6 idle at 1
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd3, 1'b0, 1'b0}, // FX at 2
        '{3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd3, 1'b0, 1'b0}, // R3 crack at 3
        '{3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd3, 1'b0, 1'b0}, // R8 pseudo
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd4, 1'b0, 1'b0}, // R6 idle at 3
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 3'd0, 1'b0, 1'b0}, // R6 idle ends
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd1, 1'b1, 1'b0}, // R7 set flag
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 3'd1, 1'b1, 1'b0}, // R7 no-op
        '{3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 3'd1, 1'b1, 1'b0}, // R9 stall wins
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 3'd1, 1'b1, 1'b1}, // R10 bad issue
        '{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 3'd1, 1'b1, 1'b1}, // R10 both
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0}, // R5 branch closes
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0}, // R7 cleared
        '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0}, // R5 single closes
        '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0}, // permute at 0
        '{3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd3, 1'b0, 1'b0}, // R3 crack adds 2
        '{3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd3, 1'b0, 1'b0}, // R4 CR at 3
        '{3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0}  // R5 branch at 3
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cand_class;
    logic       cand_first_only, cand_single, cand_cracked;
    logic       cand_sets_ctr, cand_uses_ctr;
    logic       issue_strb, idle_strb;
    logic [1:0] verdict;
    logic [2:0] slots_used;
    logic       ctr_armed;
    logic       proto_err;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dgrp_slot_gate u_dgrp_slot_gate (
        .clk             (clk),
        .rst             (rst),
        .cand_class      (cand_class),
        .cand_first_only (cand_first_only),
        .cand_single     (cand_single),
        .cand_cracked    (cand_cracked),
        .cand_sets_ctr   (cand_sets_ctr),
        .cand_uses_ctr   (cand_uses_ctr),
        .issue_strb      (issue_strb),
        .idle_strb       (idle_strb),
        .verdict         (verdict),
        .slots_used      (slots_used),
        .ctr_armed       (ctr_armed),
        .proto_err       (proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cand_class      = v.cls;
        cand_first_only = v.fo;
        cand_single     = v.sg;
        cand_cracked    = v.ck;
        cand_sets_ctr   = v.sc;
        cand_uses_ctr   = v.uc;
        issue_strb      = v.iss;
        idle_strb       = v.idl;
    endtask

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        drive('0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk("R11 slots after reset", int'(slots_used), 0);
        chk("R11 flag after reset", int'(ctr_armed), 0);
        chk("R11 verdict after reset", int'(verdict), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            #1;
            chk($sformatf("vector %0d verdict", i), int'(verdict), int'(TBL[i].ev));
            chk($sformatf("vector %0d proto_err", i), int'(proto_err), int'(TBL[i].ee));
            @(posedge clk);
            #1;
            chk($sformatf("vector %0d slots", i), int'(slots_used), int'(TBL[i].eu));
            chk($sformatf("vector %0d flag", i), int'(ctr_armed), int'(TBL[i].ea));
        end

        // R6: idle strobes fill an armed group and clear the flag
        @(negedge clk);
        drive('{3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0});
        @(posedge clk);
        #1;
        chk("R7 flag set again", int'(ctr_armed), 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive('{3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0});
            @(posedge clk);
            #1;
        end
        chk("R6 idle fill slots", int'(slots_used), 0);
        chk("R6 idle fill flag", int'(ctr_armed), 0);

        // R11: reset in mid-group
        @(negedge clk);
        drive('{3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0});
        @(posedge clk);
        #1;
        chk("R3 cracked from empty", int'(slots_used), 2);
        @(negedge clk);
        drive('0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 mid-group reset slots", int'(slots_used), 0);
        chk("R11 mid-group reset flag", int'(ctr_armed), 0);
        @(negedge clk);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule